// File: doc/BRIEF.md
# Single-Wire Battery Gauge Bus Master

This block is a memory-mapped master for a single-wire, half-duplex bus of the kind used by battery fuel gauges. Software writes a byte into a transmit register and then sets a self-clearing GO bit in the control register. The INIT and DIR control bits select one of three operations: a break pulse that resets the slave, a byte sent to the slave, or a byte read back from the slave. The line is open-drain, so the block can only pull it low or release it. Every bit cell starts with a low pulse, and the length of that pulse carries the bit value. A clock prescaler produces ticks, and every pulse width and window is a whole number of ticks.

When an operation ends, one of three sticky flags is set: transmit done, receive done, or timeout. A read of the flag register returns the flags and clears them. The interrupt output is high while any flag is set and interrupts are enabled. GO, and INIT after a break, return to zero only once interrupts are enabled. A soft reset clears all state, aborts any operation, and is reported on a done bit. A read-only word reports the revision.

The sequencer states are:
- **IDLE**: waits for a launch and moves to BRK_LOW, TX_LOW or RX_WAIT.
- **BRK_LOW**: holds the line low for the break time, then moves to BRK_REC.
- **BRK_REC**: releases the line for the recovery time, then returns to IDLE and raises timeout.
- **TX_LOW** and **TX_HIGH**: drive the low part and then the released part of each cell. After the eighth cell the sequencer returns to IDLE and raises transmit done.
- **RX_WAIT**: waits for the slave's falling edge and moves to RX_SAMPLE. If the response window expires, it returns to IDLE and raises timeout.
- **RX_SAMPLE**: samples the line a fixed time after the falling edge, then moves to RX_RELEASE.
- **RX_RELEASE**: waits for the line to rise. It then goes back to RX_WAIT, or after the eighth bit to IDLE with receive done. If the line stays low past the window, it raises timeout.

A soft reset forces the sequencer to IDLE from any state.

Top module: `sgw_master`

## Requirements
- R1: Register offsets are 0x00 revision, 0x04 transmit byte, 0x08 received byte, 0x0C control, 0x10 flags, 0x14 configuration and 0x18 status.
  - The revision reads {REV_MAJOR, REV_MINOR} as two nibbles.
  - After reset, control, flags, configuration and the received byte read 0, status bit 0 reads 1, and the interrupt is low.
- R2: Control is written 0x70 (bit 6 interrupt enable, bit 5 clock enable, bit 4 GO, bit 2 INIT=0, bit 1 DIR=0). The transmit byte then goes out LSB first, with one cell of CELL_TICKS*PRESCALE clocks per bit. A 1 is a low of LOW1_TICKS*PRESCALE clocks and a 0 is a low of LOW0_TICKS*PRESCALE clocks.
- R3: A finished transmit sets flag bit 2 only, and GO returns to 0.
- R4: GO with INIT set pulls the line low for BREAK_TICKS*PRESCALE clocks, then releases it for RECOVER_TICKS ticks. It then sets flag bit 0 only, and both GO and INIT return to 0.
- R5: GO with DIR set receives 8 bits, LSB first. Each bit is the synchronised line level SAMPLE_TICKS ticks after the slave's falling edge. The byte appears at offset 0x08 and flag bit 1 is set.
- R6: In a receive, if no falling edge arrives within WINDOW_TICKS ticks, the block sets flag bit 0 only and clears GO. The received byte keeps its old value.
- R7: A read of the flag register returns the flags and clears them. A flag set in the same cycle as the read is kept and seen by the next read.
- R8: The interrupt is high exactly when bit 6 of control is 1 and any flag is set.
- R9: With interrupt enable at 0, GO and INIT stay at 1 after the operation ends. They clear once interrupt enable is written to 1.
- R10: A control write while GO is 1 changes only bits 6, 5 and 0. It neither starts a second operation nor alters the direction of the current one.
- R11: While clock enable is 0, a GO request waits: the line stays released and no flag is set. The operation runs once clock enable is set.
- R12: A configuration write with bit 1 set aborts any operation, releases the line and clears all registers. Status bit 0 reads 0 for SRST_CYCLES cycles and then 1. Configuration bit 0 (auto-idle) reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the flags at offset 0x10) |
| reg_addr | input | 5 | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of reg_rd |
| irq | output | 1 | Interrupt request |
| line_in | input | 1 | Bus line level, asynchronous |
| line_pull_low | output | 1 | 1 pulls the open-drain line low |

## Verification
A completion flag can be set by the sequencer in the same cycle that software reads and clears the flag register. The bench provokes this overlap by holding a flag read active on every cycle of several transfers. In that case the completion edge always meets a clearing read. The result is judged by requiring that the transmit-done flag appears in exactly one of the back-to-back reads, never zero times and never twice.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    typedef enum logic [1:0] {OP_TX, OP_RX, OP_BRK} op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_BRK_LOW, S_BRK_REC, S_TX_LOW,
        S_TX_HIGH, S_RX_WAIT, S_RX_SAMPLE, S_RX_RELEASE
    } state_e;

    // bit order matches the flag register: [2] tx, [1] rx, [0] timeout
    typedef struct packed {
        logic tx;
        logic rx;
        logic tmo;
    } evt_t;

    localparam logic [4:0] A_REV   = 5'h00;
    localparam logic [4:0] A_TXD   = 5'h04;
    localparam logic [4:0] A_RXD   = 5'h08;
    localparam logic [4:0] A_CTRL  = 5'h0C;
    localparam logic [4:0] A_FLAG  = 5'h10;
    localparam logic [4:0] A_SCFG  = 5'h14;
    localparam logic [4:0] A_SSTAT = 5'h18;

    localparam int C_IE   = 6;
    localparam int C_CE   = 5;
    localparam int C_GO   = 4;
    localparam int C_INIT = 2;
    localparam int C_DIR  = 1;
    localparam int C_MODE = 0;

endpackage

// File: rtl/sgw_prescale.sv
module sgw_prescale #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PW-1:0] pcnt;

    // held at zero while stopped, so the first tick lands DIV clocks after start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        pcnt <= '0;
        else if (!run)                     pcnt <= '0;
        else if (pcnt == PW'(DIV - 1))     pcnt <= '0;
        else                               pcnt <= pcnt + 1'b1;
    end

    assign tick = run && (pcnt == PW'(DIV - 1));
endmodule

// File: rtl/sgw_sync.sv
module sgw_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b1;
            q    <= 1'b1;
        end else begin
            meta <= d_async;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sgw_engine.sv
module sgw_engine
    import sgw_pkg::*;
#(
    parameter int CELL_TICKS    = 48,
    parameter int LOW1_TICKS    = 10,
    parameter int LOW0_TICKS    = 30,
    parameter int BREAK_TICKS   = 60,
    parameter int RECOVER_TICKS = 12,
    parameter int SAMPLE_TICKS  = 20,
    parameter int WINDOW_TICKS  = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       start,
    input  op_e        op,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       line_s,
    output logic       pull_low,
    output logic       busy,
    output evt_t       evt,
    output logic [7:0] rx_byte
);
    localparam int MAXA = (CELL_TICKS > BREAK_TICKS) ? CELL_TICKS : BREAK_TICKS;
    localparam int MAXB = (WINDOW_TICKS > RECOVER_TICKS) ? WINDOW_TICKS : RECOVER_TICKS;
    localparam int MAXT = (MAXA > MAXB) ? MAXA : MAXB;
    localparam int CW   = $clog2(MAXT + 1);

    state_e        state, nxt;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    shreg;
    logic [CW-1:0] low_len;
    logic [CW-1:0] high_end;
    logic          last_bit;
    logic          smp;

    assign low_len  = shreg[0] ? CW'(LOW1_TICKS) : CW'(LOW0_TICKS);
    assign high_end = CW'(CELL_TICKS) - low_len - CW'(1);
    assign last_bit = (bitn == 3'd7);
    assign smp      = (state == S_RX_SAMPLE) && tick && (cnt == CW'(SAMPLE_TICKS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions and completion events
    always_comb begin
        nxt = state;
        evt = '0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    unique case (op)
                        OP_BRK:  nxt = S_BRK_LOW;
                        OP_RX:   nxt = S_RX_WAIT;
                        default: nxt = S_TX_LOW;
                    endcase
                end
            end
            S_BRK_LOW:
                if (tick && cnt == CW'(BREAK_TICKS - 1)) nxt = S_BRK_REC;
            S_BRK_REC:
                if (tick && cnt == CW'(RECOVER_TICKS - 1)) begin
                    nxt     = S_IDLE;
                    evt.tmo = 1'b1;
                end
            S_TX_LOW:
                if (tick && cnt == low_len - CW'(1)) nxt = S_TX_HIGH;
            S_TX_HIGH:
                if (tick && cnt == high_end) begin
                    if (last_bit) begin
                        nxt    = S_IDLE;
                        evt.tx = 1'b1;
                    end else begin
                        nxt = S_TX_LOW;
                    end
                end
            S_RX_WAIT:
                if (!line_s) nxt = S_RX_SAMPLE;
                else if (tick && cnt == CW'(WINDOW_TICKS - 1)) begin
                    nxt     = S_IDLE;
                    evt.tmo = 1'b1;
                end
            S_RX_SAMPLE:
                if (smp) nxt = S_RX_RELEASE;
            S_RX_RELEASE:
                if (line_s) begin
                    if (last_bit) begin
                        nxt    = S_IDLE;
                        evt.rx = 1'b1;
                    end else begin
                        nxt = S_RX_WAIT;
                    end
                end else if (tick && cnt == CW'(WINDOW_TICKS - 1)) begin
                    nxt     = S_IDLE;
                    evt.tmo = 1'b1;
                end
            default: nxt = S_IDLE;
        endcase
        if (abort) begin
            nxt = S_IDLE;
            evt = '0;
        end
    end

    // tick counter, bit counter, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else begin
            if (nxt != state) cnt <= '0;
            else if (tick)    cnt <= cnt + 1'b1;

            if (state == S_IDLE) begin
                bitn <= '0;
                if (start) shreg <= tx_byte;
            end else if (state == S_TX_HIGH && nxt == S_TX_LOW) begin
                bitn  <= bitn + 1'b1;
                shreg <= {1'b0, shreg[7:1]};
            end else if (smp) begin
                shreg <= {line_s, shreg[7:1]};
            end else if (state == S_RX_RELEASE && nxt == S_RX_WAIT) begin
                bitn <= bitn + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pull_low = (state == S_BRK_LOW) || (state == S_TX_LOW);
        busy     = (state != S_IDLE);
        rx_byte  = shreg;
    end

    // R3, R5, R6: an operation ends with at most one kind of completion
    p_single_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt));

endmodule

// File: rtl/sgw_master.sv
module sgw_master
    import sgw_pkg::*;
#(
    parameter int PRESCALE      = 8,
    parameter int CELL_TICKS    = 48,
    parameter int LOW1_TICKS    = 10,
    parameter int LOW0_TICKS    = 30,
    parameter int BREAK_TICKS   = 60,
    parameter int RECOVER_TICKS = 12,
    parameter int SAMPLE_TICKS  = 20,
    parameter int WINDOW_TICKS  = 100,
    parameter int SRST_CYCLES   = 4,
    parameter int REV_MAJOR     = 1,
    parameter int REV_MINOR     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [4:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       line_in,
    output logic       line_pull_low
);
    localparam int RCW = $clog2(SRST_CYCLES + 1);

    logic ie, ce, go, init, dir, mode, req, pend, autoidle;
    logic [7:0]     txd, rxd;
    logic [2:0]     flags;
    logic [RCW-1:0] srst_cnt;
    logic           srst_act;

    logic       line_s, tick, launch, eng_busy;
    evt_t       eng_evt;
    logic [2:0] evt_bits;
    logic [7:0] eng_rx;
    op_e        op_sel;

    logic wr_ctrl, wr_txd, wr_scfg, rd_flags;

    assign srst_act = (srst_cnt != '0);
    assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
    assign wr_txd   = reg_wr && reg_addr == A_TXD;
    assign wr_scfg  = reg_wr && reg_addr == A_SCFG;
    assign rd_flags = reg_rd && reg_addr == A_FLAG && !srst_act;
    assign launch   = req && ce && !eng_busy && !srst_act;
    assign op_sel   = init ? OP_BRK : (dir ? OP_RX : OP_TX);
    assign evt_bits = {eng_evt.tx, eng_evt.rx, eng_evt.tmo};
    assign irq      = ie && (flags != 3'b000);

    sgw_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(line_in),
        .q      (line_s)
    );

    sgw_prescale #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (eng_busy && ce),
        .tick (tick)
    );

    sgw_engine #(
        .CELL_TICKS   (CELL_TICKS),
        .LOW1_TICKS   (LOW1_TICKS),
        .LOW0_TICKS   (LOW0_TICKS),
        .BREAK_TICKS  (BREAK_TICKS),
        .RECOVER_TICKS(RECOVER_TICKS),
        .SAMPLE_TICKS (SAMPLE_TICKS),
        .WINDOW_TICKS (WINDOW_TICKS)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (srst_act),
        .start   (launch),
        .op      (op_sel),
        .tx_byte (txd),
        .tick    (tick),
        .line_s  (line_s),
        .pull_low(line_pull_low),
        .busy    (eng_busy),
        .evt     (eng_evt),
        .rx_byte (eng_rx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {ie, ce, go, init, dir, mode, req, pend, autoidle} <= '0;
            txd      <= '0;
            rxd      <= '0;
            flags    <= '0;
            srst_cnt <= '0;
        end else if (srst_act) begin
            {ie, ce, go, init, dir, mode, req, pend, autoidle} <= '0;
            txd      <= '0;
            rxd      <= '0;
            flags    <= '0;
            srst_cnt <= srst_cnt - 1'b1;
        end else begin
            if (wr_txd) txd <= reg_wdata;
            if (wr_scfg) begin
                autoidle <= reg_wdata[0];
                if (reg_wdata[1]) srst_cnt <= RCW'(SRST_CYCLES);
            end
            if (wr_ctrl) begin
                ie   <= reg_wdata[C_IE];
                ce   <= reg_wdata[C_CE];
                mode <= reg_wdata[C_MODE];
                if (!go && reg_wdata[C_GO]) begin
                    go   <= 1'b1;
                    init <= reg_wdata[C_INIT];
                    dir  <= reg_wdata[C_DIR];
                    req  <= 1'b1;
                end
            end
            if (launch) req <= 1'b0;
            flags <= (rd_flags ? 3'b000 : flags) | evt_bits;
            if (eng_evt.rx) rxd <= eng_rx;
            if (evt_bits != 3'b000) begin
                pend <= 1'b1;
            end else if (pend && ie) begin
                pend <= 1'b0;
                go   <= 1'b0;
                init <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                A_REV:   reg_rdata = {4'(REV_MAJOR), 4'(REV_MINOR)};
                A_TXD:   reg_rdata = txd;
                A_RXD:   reg_rdata = rxd;
                A_CTRL:  reg_rdata = {1'b0, ie, ce, go, 1'b0, init, dir, mode};
                A_FLAG:  reg_rdata = {5'b0, flags};
                A_SCFG:  reg_rdata = {6'b0, srst_act, autoidle};
                A_SSTAT: reg_rdata = {7'b0, !srst_act};
                default: reg_rdata = '0;
            endcase
        end
    end

    // R2: the line is only pulled while an operation is outstanding
    p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !go |-> !line_pull_low);

    // R3: a completion only occurs for an operation that software started
    p_evt_needs_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_bits != 3'b000) |-> go);

    // R7: a read with no coincident completion leaves the flags empty
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && evt_bits == 3'b000) |=> (flags == 3'b000));

    // R9: GO persists while interrupts are disabled
    p_go_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ie && !srst_act) |=> go);

    // R12: soft reset releases the line
    p_srst_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        srst_act |=> !line_pull_low);

endmodule

// File: tb/sgw_master_tb_top.sv
module sgw_master_tb_top;

    localparam int P    = 2;
    localparam int CELL = 20;
    localparam int L1   = 4;
    localparam int L0   = 12;
    localparam int BRK  = 30;
    localparam int REC  = 8;
    localparam int SMP  = 8;
    localparam int WIN  = 40;
    localparam int SRST = 4;
    localparam int THR  = (L1 + L0) * P / 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr, reg_rd;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       irq, line_pull_low, slave_pull;
    logic       line_w;

    always #5 clk = ~clk;
    assign line_w = ~(line_pull_low | slave_pull);

    sgw_master #(
        .PRESCALE(P), .CELL_TICKS(CELL), .LOW1_TICKS(L1), .LOW0_TICKS(L0),
        .BREAK_TICKS(BRK), .RECOVER_TICKS(REC), .SAMPLE_TICKS(SMP),
        .WINDOW_TICKS(WIN), .SRST_CYCLES(SRST), .REV_MAJOR(2), .REV_MINOR(5)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .line_in(line_w), .line_pull_low(line_pull_low)
    );

    int checks = 0;
    int fails  = 0;

    // line monitor: decodes low pulses into bits, LSB first
    int         lowcnt = 0;
    int         mon_bits = 0;
    int         mon_last_low = 0;
    logic [7:0] mon_byte = 8'h00;

    always @(negedge clk) begin
        if (!line_w) lowcnt = lowcnt + 1;
        else if (lowcnt != 0) begin
            mon_last_low = lowcnt;
            mon_byte     = {(lowcnt < THR), mon_byte[7:1]};
            mon_bits     = mon_bits + 1;
            lowcnt       = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(input int maxc, output int cyc);
        cyc = 0;
        while (!irq && cyc < maxc) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic mon_clear();
        @(negedge clk);
        #2;
        mon_bits = 0;
        mon_byte = 8'h00;
    endtask

    task automatic slave_send(input logic [7:0] v);
        repeat (10) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            slave_pull = 1'b1;
            repeat (v[b] ? L1 * P : L0 * P) @(negedge clk);
            slave_pull = 1'b0;
            repeat (v[b] ? (CELL - L1) * P : (CELL - L0) * P) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int         cyc;
        logic [7:0] v;
        logic [7:0] last_rx;
        int         seen;
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0; slave_pull = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and register map
        rd(5'h00, d); chk("R1 revision", d, 8'h25);
        rd(5'h0C, d); chk("R1 control reset", d, 0);
        rd(5'h10, d); chk("R1 flags reset", d, 0);
        rd(5'h18, d); chk("R1 status reset", d, 1);
        rd(5'h14, d); chk("R1 config reset", d, 0);
        rd(5'h08, d); chk("R1 rx reset", d, 0);
        chk("R1 irq reset", irq, 0);

        // sweep: alternating transmit and receive of computed bytes
        last_rx = 8'h00;
        for (int i = 0; i < 40; i++) begin
            v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 53 + 7) & 255);
            if (i % 2 == 0) begin
                mon_clear();
                wr(5'h04, v);
                wr(5'h0C, 8'h70);
                wait_irq(600, cyc);
                chk("R2 tx byte on line", mon_byte, v);
                chk("R2 tx bit count", mon_bits, 8);
                rd(5'h10, d); chk("R3 tx flag", d, 8'h04);
                rd(5'h0C, d); chk("R3 go cleared", d, 8'h60);
                chk("R8 irq low after read", irq, 0);
            end else begin
                wr(5'h0C, 8'h72);
                slave_send(v);
                wait_irq(300, cyc);
                rd(5'h08, d); chk("R5 rx byte", d, v);
                rd(5'h10, d); chk("R5 rx flag", d, 8'h02);
                rd(5'h0C, d); chk("R5 go cleared", d, 8'h62);
                last_rx = v;
            end
        end

        // R6 receive timeout
        wr(5'h0C, 8'h72);
        wait_irq(300, cyc);
        chk_rng("R6 timeout delay", cyc, WIN * P - 2, WIN * P + 6);
        rd(5'h10, d); chk("R6 timeout flag", d, 8'h01);
        rd(5'h08, d); chk("R6 rx unchanged", d, last_rx);
        rd(5'h0C, d); chk("R6 go cleared", d, 8'h62);

        // R4 break
        wr(5'h0C, 8'h74);
        wait_irq(300, cyc);
        chk_rng("R4 break low width", mon_last_low, BRK * P - 1, BRK * P + 1);
        chk_rng("R4 break total time", cyc, (BRK + REC) * P - 2, (BRK + REC) * P + 4);
        rd(5'h10, d); chk("R4 break flag", d, 8'h01);
        rd(5'h0C, d); chk("R4 go and init cleared", d, 8'h60);

        // R9, R8: interrupts disabled keep GO and INIT; irq stays low
        wr(5'h0C, 8'h34);
        repeat (150) @(negedge clk);
        rd(5'h0C, d); chk("R9 go held", d, 8'h34);
        chk("R8 irq masked", irq, 0);
        wr(5'h0C, 8'h74);
        repeat (2) @(negedge clk);
        rd(5'h0C, d); chk("R9 go cleared after enable", d, 8'h60);
        chk("R8 irq raised", irq, 1);
        rd(5'h10, d); chk("R9 break flag", d, 8'h01);

        // R10: control write during transmit is ignored for GO and DIR
        mon_clear();
        wr(5'h04, 8'hA5);
        wr(5'h0C, 8'h70);
        repeat (50) @(negedge clk);
        wr(5'h0C, 8'h72);
        wait_irq(600, cyc);
        rd(5'h10, d); chk("R10 only tx flag", d, 8'h04);
        chk("R10 byte intact", mon_byte, 8'hA5);
        rd(5'h0C, d); chk("R10 dir unchanged", d, 8'h60);
        repeat (200) @(negedge clk);
        chk("R10 no second operation", mon_bits, 8);
        rd(5'h10, d); chk("R10 no late flag", d, 0);

        // R11: clock enable gates the launch
        mon_clear();
        wr(5'h04, 8'h3C);
        wr(5'h0C, 8'h50);
        repeat (200) @(negedge clk);
        chk("R11 line idle", mon_bits, 0);
        rd(5'h10, d); chk("R11 no flag", d, 0);
        rd(5'h0C, d); chk("R11 go pending", d, 8'h50);
        wr(5'h0C, 8'h70);
        wait_irq(600, cyc);
        chk("R11 runs after enable", mon_byte, 8'h3C);
        rd(5'h10, d); chk("R11 tx flag", d, 8'h04);

        // R7: read flags on every cycle across transfers
        for (int k = 0; k < 3; k++) begin
            wr(5'h04, 8'(8'h5A + k * 8'h31));
            wr(5'h0C, 8'h70);
            seen = 0;
            @(negedge clk);
            reg_rd = 1'b1; reg_addr = 5'h10;
            for (int c = 0; c < 400; c++) begin
                #1;
                if (reg_rdata[2]) seen++;
                @(negedge clk);
            end
            reg_rd = 1'b0;
            chk("R7 flag seen once", seen, 1);
        end

        // R12: soft reset and auto-idle readback
        wr(5'h14, 8'h01);
        rd(5'h14, d); chk("R12 autoidle readback", d, 8'h01);
        wr(5'h04, 8'h3C);
        wr(5'h0C, 8'h70);
        repeat (30) @(negedge clk);
        wr(5'h14, 8'h03);
        rd(5'h18, d); chk("R12 reset busy", d, 0);
        repeat (SRST + 4) @(negedge clk);
        rd(5'h18, d); chk("R12 reset done", d, 1);
        rd(5'h0C, d); chk("R12 control cleared", d, 0);
        rd(5'h14, d); chk("R12 config cleared", d, 0);
        rd(5'h04, d); chk("R12 tx cleared", d, 0);
        rd(5'h10, d); chk("R12 flags cleared", d, 0);
        chk("R12 line released", line_w, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule